// File: doc/BRIEF.md
# Stretched Bidirectional Reset Controller

This block sequences reset for a core whose reset pin is both an input and an open-drain output. It watches the external active-low pin through a synchronizer and collects internal reset requests such as a watchdog expiry or a software reset. On any reset cause it holds the core in reset and, unless masked, pulls its own pin low. The pull-down lasts a fixed number of state times, so the rest of the board sees a reset pulse of known width.

Time is counted in state times, marked by a one-cycle `state_tick` strobe from the clock unit. The pin is level sensitive: while it reads low, the core stays in reset however long that lasts. A configuration input can stop internal requests from reaching the pin. When the core leaves reset, the block pulses a start strobe to the fetch unit, which loads the fixed boot vector. When reset is entered it pulses a strobe that clears the idle and powerdown flags, so a reset taken from a low-power mode returns the core to normal operation.

Top module: `rst_stretch_ctrl`

## Requirements
- R1: A falling edge on the pin, seen through a two-flop synchronizer, turns on `pin_pd_en` for exactly 16 state times (16 cycles when `state_tick` is high in every cycle).
- R2: An internal request with `int_pin_mask` = 0 turns on `pin_pd_en` for 16 state times.
- R3: An internal request with `int_pin_mask` = 1 holds `core_rst` for 16 state times and leaves `pin_pd_en` at 0.
- R4: `core_rst` is 1 while the synchronized pin is low and while the stretch runs. It is 1 in every cycle in which `pin_pd_en` is 1, and it goes low only at an edge where `state_tick` was 1, namely the first state time after both conditions end.
- R5: A new reset request during an active stretch reloads the count to 16. The pull-down covers 16 state times from the latest request.
- R6: The pin falling because of the block's own pull-down is not taken as an external edge, so a stretch never retriggers itself.
- R7: `fetch_go` pulses for exactly one cycle, in the cycle after `core_rst` falls. `fetch_addr` is always 24'hFF2080.
- R8: `lp_clear` pulses for one cycle when `core_rst` rises from 0. This is how a pin reset taken during idle or powerdown returns the core to normal mode.
- R9: While `por_n` is low, `core_rst` = 1 and `pin_pd_en` = 0. After `por_n` rises, with the pin high, the core leaves reset on the first state tick.
- R10: The stretch count moves only on `state_tick`. With a tick every third cycle, the pull-down lasts 46 to 48 cycles, depending on tick phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| state_tick | input | 1 | One-cycle strobe marking each state time |
| pin_n_in | input | 1 | Raw level read back from the reset pin, active low |
| int_req | input | NUM_REQ | Internal reset requests, one per source, active high |
| int_pin_mask | input | 1 | 1 keeps internal requests off the pin |
| pin_pd_en | output | 1 | Enable of the pin's open-drain pull-down |
| core_rst | output | 1 | Reset to the core, active high |
| lp_clear | output | 1 | One-cycle strobe clearing the idle and powerdown flags |
| fetch_go | output | 1 | One-cycle strobe telling the fetch unit to start |
| fetch_addr | output | ADDR_W | Address of the first instruction fetch |

## Verification
The bench models the pin as a wired-AND of the external driver and the block's own pull-down, so the pull-down reaches the synchronizer. A design without the self-edge guard would retrigger forever and never release the core. The bench sends requests in the middle of a stretch, where a design that ignores them gives a pulse too short. It holds the pin low far beyond the stretch, where a design that releases on count alone lets the core run while the pin still reads low. It also checks masked internal resets, which must reset the core without driving the pin, and slow tick rates, which expose a counter that runs on clock cycles rather than state times.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned        DEF_STRETCH  = 16;
    localparam int unsigned        DEF_ADDR_W   = 24;
    localparam logic [23:0]        DEF_BOOT_VEC = 24'hFF2080;

    // registered sequencing outputs of the top level
    typedef struct packed {
        logic core_rst;
        logic fetch_go;
        logic lp_clear;
    } seq_state_t;

endpackage

// File: rtl/rstc_pin_sync.sv
module rstc_pin_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n_in,
    input  logic self_pd,
    output logic pin_low,
    output logic ext_fall
);

    localparam int unsigned HIST_W = STAGES + 1;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic [HIST_W-1:0] hist;
    } sync_t;

    sync_t sync_d, sync_q;

    logic synced;
    assign synced = sync_q.chain[STAGES-1];

    always_comb begin
        sync_d       = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], pin_n_in};
        sync_d.prev  = synced;
        // remember recent own pull-down so its echo is not an edge
        sync_d.hist  = {sync_q.hist[HIST_W-2:0], self_pd};
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            sync_q.chain <= '1;
            sync_q.prev  <= 1'b1;
            sync_q.hist  <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign pin_low  = ~synced;
    assign ext_fall = sync_q.prev & ~synced & ~self_pd & ~(|sync_q.hist);

endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
    parameter int unsigned STRETCH = 16
) (
    input  logic clk,
    input  logic por_n,
    input  logic state_tick,
    input  logic start,
    input  logic drive_pin,
    output logic busy_next,
    output logic pd_en
);

    localparam int unsigned CNT_W = $clog2(STRETCH + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pin_mode;
    } str_t;

    str_t str_d, str_q;

    logic busy;
    assign busy = (str_q.cnt != '0);

    always_comb begin
        str_d = str_q;
        if (start) begin
            str_d.cnt      = LOAD;
            str_d.pin_mode = (busy & str_q.pin_mode) | drive_pin;
        end else if (state_tick && busy) begin
            str_d.cnt = str_q.cnt - 1'b1;
        end
        if (str_d.cnt == '0) begin
            str_d.pin_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            str_q <= '0;
        end else begin
            str_q <= str_d;
        end
    end

    assign busy_next = (str_d.cnt != '0);
    assign pd_en     = busy & str_q.pin_mode;

    // R5: any request reloads the full count
    a_r5_restart_loads: assert property (@(posedge clk) disable iff (!por_n)
        start |=> (str_q.cnt == LOAD));

    // R10: the count moves only on a state tick or a new request
    a_r10_tick_only: assert property (@(posedge clk) disable iff (!por_n)
        (!state_tick && !start) |=> $stable(str_q.cnt));

    // R3: a masked request on an idle block never drives the pin
    a_r3_masked_quiet: assert property (@(posedge clk) disable iff (!por_n)
        (start && !drive_pin && !busy) |=> !pd_en);

endmodule

// File: rtl/rst_stretch_ctrl.sv
module rst_stretch_ctrl
    import rstc_pkg::*;
#(
    parameter int unsigned NUM_REQ     = 2,
    parameter int unsigned STRETCH     = DEF_STRETCH,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = DEF_ADDR_W,
    parameter logic [ADDR_W-1:0] BOOT_VEC = ADDR_W'(DEF_BOOT_VEC)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              state_tick,
    input  logic              pin_n_in,
    input  logic [NUM_REQ-1:0] int_req,
    input  logic              int_pin_mask,
    output logic              pin_pd_en,
    output logic              core_rst,
    output logic              lp_clear,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_addr
);

    logic pin_low;
    logic ext_fall;
    logic any_int;
    logic start;
    logic drive_pin;
    logic busy_next;
    logic pd_en;

    rstc_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .pin_n_in (pin_n_in),
        .self_pd  (pd_en),
        .pin_low  (pin_low),
        .ext_fall (ext_fall)
    );

    assign any_int   = |int_req;
    assign start     = ext_fall | any_int;
    assign drive_pin = ext_fall | (any_int & ~int_pin_mask);

    rstc_stretch #(
        .STRETCH (STRETCH)
    ) u_stretch (
        .clk        (clk),
        .por_n      (por_n),
        .state_tick (state_tick),
        .start      (start),
        .drive_pin  (drive_pin),
        .busy_next  (busy_next),
        .pd_en      (pd_en)
    );

    seq_state_t seq_d, seq_q;
    logic hold;

    always_comb begin
        seq_d          = seq_q;
        hold           = start | busy_next | pin_low;
        // release only on a state-time boundary
        seq_d.core_rst = hold | (seq_q.core_rst & ~state_tick);
        seq_d.fetch_go = seq_q.core_rst & ~seq_d.core_rst;
        seq_d.lp_clear = ~seq_q.core_rst & seq_d.core_rst;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            seq_q.core_rst <= 1'b1;
            seq_q.fetch_go <= 1'b0;
            seq_q.lp_clear <= 1'b0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pin_pd_en  = pd_en;
    assign core_rst   = seq_q.core_rst;
    assign lp_clear   = seq_q.lp_clear;
    assign fetch_go   = seq_q.fetch_go;
    assign fetch_addr = BOOT_VEC;

    // R4: the core is in reset whenever the pin is being pulled
    a_r4_core_covers_pd: assert property (@(posedge clk) disable iff (!por_n)
        pin_pd_en |-> core_rst);

    // R4: release happens on a state-time boundary
    a_r4_release_on_tick: assert property (@(posedge clk) disable iff (!por_n)
        $fell(core_rst) |-> $past(state_tick));

    // R7: fetch start follows the release and lasts one cycle
    a_r7_fetch_after_release: assert property (@(posedge clk) disable iff (!por_n)
        fetch_go |-> (!core_rst && $past(core_rst)));

    a_r7_fetch_single: assert property (@(posedge clk) disable iff (!por_n)
        fetch_go |=> !fetch_go);

    // R8: low-power flags are cleared only on reset entry
    a_r8_lp_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        lp_clear |-> (core_rst && !$past(core_rst)));

endmodule

// File: tb/rst_stretch_ctrl_test.sv
module rst_stretch_ctrl_test;

    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       state_tick = 1'b1;
    logic       ext_n = 1'b1;
    logic [1:0] int_req = '0;
    logic       int_pin_mask = 1'b0;
    logic       pin_pd_en, core_rst, lp_clear, fetch_go;
    logic [23:0] fetch_addr;
    logic       pin_n_in;

    // open-drain pin: external driver and own pull-down
    assign pin_n_in = ext_n & ~pin_pd_en;

    rst_stretch_ctrl uut (
        .clk          (clk),
        .por_n        (por_n),
        .state_tick   (state_tick),
        .pin_n_in     (pin_n_in),
        .int_req      (int_req),
        .int_pin_mask (int_pin_mask),
        .pin_pd_en    (pin_pd_en),
        .core_rst     (core_rst),
        .lp_clear     (lp_clear),
        .fetch_go     (fetch_go),
        .fetch_addr   (fetch_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_div = 1;
    int tick_ph  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference ----------------
    bit m_s1 = 1, m_s2 = 1, m_prev = 1;
    bit m_h[3] = '{0, 0, 0};
    int m_cnt = 0;
    bit m_mode = 0, m_core = 1, m_fetch = 0, m_lp = 0;

    function automatic bit m_pd();
        return (m_cnt != 0) && m_mode;
    endfunction

    always @(posedge clk) begin
        if (!por_n) begin
            m_s1 = 1; m_s2 = 1; m_prev = 1; m_h = '{0, 0, 0};
            m_cnt = 0; m_mode = 0; m_core = 1; m_fetch = 0; m_lp = 0;
        end else begin
            bit pd, pin, fall, req, start, drive, hold, ncore;
            int ncnt;
            bit nmode;
            pd    = m_pd();
            pin   = ext_n & ~pd;
            fall  = m_prev & ~m_s2 & ~(pd | m_h[0] | m_h[1] | m_h[2]);
            req   = (int_req != 0);
            start = fall | req;
            drive = fall | (req & ~int_pin_mask);
            ncnt  = m_cnt;
            nmode = m_mode;
            if (start) begin
                nmode = ((m_cnt != 0) && m_mode) | drive;
                ncnt  = 16;
            end else if (state_tick && m_cnt > 0) begin
                ncnt = m_cnt - 1;
            end
            if (ncnt == 0) nmode = 0;
            hold    = start | (ncnt != 0) | ~m_s2;
            ncore   = hold | (m_core & ~state_tick);
            m_fetch = m_core & ~ncore;
            m_lp    = ~m_core & ncore;
            m_core  = ncore;
            m_cnt   = ncnt;
            m_mode  = nmode;
            m_h[2]  = m_h[1]; m_h[1] = m_h[0]; m_h[0] = pd;
            m_prev  = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int pd_cycles = 0, core_cycles = 0, fetch_cnt = 0, lp_cnt = 0;

    always @(negedge clk) begin
        if (por_n) begin
            check(pin_pd_en == m_pd(), "R1 model pull-down", pin_pd_en, m_pd());
            check(core_rst == m_core, "R4 model core reset", core_rst, m_core);
            check(fetch_go == m_fetch, "R7 model fetch start", fetch_go, m_fetch);
            check(lp_clear == m_lp, "R8 model low-power clear", lp_clear, m_lp);
            pd_cycles   += pin_pd_en;
            core_cycles += core_rst;
            fetch_cnt   += fetch_go;
            lp_cnt      += lp_clear;
        end
        // tick generator, driven away from the active edge
        tick_ph    = (tick_ph + 1) % tick_div;
        state_tick = (tick_ph == 0);
    end

    task automatic clr();
        pd_cycles = 0; core_cycles = 0; fetch_cnt = 0; lp_cnt = 0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_req(input int idx);
        @(negedge clk);
        int_req[idx] = 1'b1;
        @(negedge clk);
        int_req[idx] = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        run(4);
        // R9: held state during power-on reset
        check(core_rst == 1'b1, "R9 core reset during por", core_rst, 1);
        check(pin_pd_en == 1'b0, "R9 no pull-down during por", pin_pd_en, 0);
        por_n = 1'b1;
        clr();
        run(6);
        check(core_rst == 1'b0, "R9 release after por", core_rst, 0);
        check(fetch_cnt == 1, "R7 one fetch start after por", fetch_cnt, 1);
        check(fetch_addr == 24'hFF2080, "R7 boot vector", int'(fetch_addr), 32'hFF2080);

        // R1 / R6 / R8: short external low pulse
        clr();
        ext_n = 1'b0; run(3); ext_n = 1'b1;
        run(40);
        check(pd_cycles == 16, "R1 pull-down width", pd_cycles, 16);
        check(lp_cnt == 1, "R8 one low-power clear", lp_cnt, 1);
        check(fetch_cnt == 1, "R7 one fetch after pin reset", fetch_cnt, 1);
        check(core_rst == 1'b0, "R4 core released", core_rst, 0);
        run(60);
        check(pd_cycles == 16, "R6 no self retrigger", pd_cycles, 16);

        // R2: unmasked internal request
        clr();
        pulse_req(1);
        run(40);
        check(pd_cycles == 16, "R2 internal pull-down width", pd_cycles, 16);

        // R3: masked internal request
        int_pin_mask = 1'b1;
        clr();
        pulse_req(0);
        run(40);
        check(pd_cycles == 0, "R3 masked no pull-down", pd_cycles, 0);
        check(core_cycles == 16, "R3 masked core reset width", core_cycles, 16);
        int_pin_mask = 1'b0;

        // R5: restart during stretch
        clr();
        @(negedge clk); int_req[0] = 1'b1; @(negedge clk); int_req[0] = 1'b0;
        run(3);
        @(negedge clk); int_req[1] = 1'b1; @(negedge clk); int_req[1] = 1'b0;
        run(50);
        check(pd_cycles == 21, "R5 restarted pull-down width", pd_cycles, 21);
        check(fetch_cnt == 1, "R5 single release after restart", fetch_cnt, 1);

        // R4: pin held low far beyond the stretch
        clr();
        ext_n = 1'b0;
        run(50);
        check(core_rst == 1'b1, "R4 core held while pin low", core_rst, 1);
        check(pd_cycles == 16, "R4 pull-down still bounded", pd_cycles, 16);
        ext_n = 1'b1;
        run(10);
        check(core_rst == 1'b0, "R4 release after pin high", core_rst, 0);

        // R10: slower state time
        tick_div = 3;
        run(5);
        clr();
        ext_n = 1'b0; run(2); ext_n = 1'b1;
        run(80);
        check(pd_cycles >= 46 && pd_cycles <= 48, "R10 pull-down in state times",
              pd_cycles, 47);
        check(fetch_cnt == 1, "R10 single release", fetch_cnt, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule